// File: doc/BRIEF.md
# DMA Block Buffer for a 128-bit Cipher Core

This block connects a 32-bit register port to a 128-bit block cipher datapath. On the input side it collects four 32-bit writes into one 128-bit block and hands that block to the core. On the output side it takes a finished 128-bit result from the core and returns it as four 32-bit reads. Each direction has its own DMA enable. While an enable is set, the block raises a request every time it needs one more word moved. Every request is answered by exactly one single 32-bit transfer.

The first word in time always fills the most significant lane, and the last word fills the least significant lane. Data passes through without any byte or bit reordering, so the lowest memory address of a DMA buffer becomes the top word of the block. Software can also write or read the same ports directly, without a DMA acknowledge. Those accesses move the same word counters, so DMA and CPU accesses can be mixed inside one block. Clearing an enable in the middle of a block restarts that direction at its top word.

Top module: `dma_blkbuf`

## Requirements
- R1: `in_req` is never high while `in_dma_en` is low. In the cycle after `in_dma_en` falls, `in_req` is low whatever the enable does in that cycle.
- R2: `out_req` is never high while `out_dma_en` is low.
- R3: `in_req` stays low from the fourth input word until the core accepts the block (`blk_valid` high means no input request).
- R4: `out_req` is raised only while a result is held, which means `res_ready` is low.
- R5: Once raised, a request stays high until its acknowledge arrives, unless its enable drops or the buffer state ends the need for it.
- R6: In the cycle after a request is acknowledged, the request is low. If more words are still needed, it is high again the cycle after that.
- R7: The k-th input word (k = 0..3) lands in bits [127-32k : 96-32k] of `blk_data` without any swapping. `blk_valid` rises in the cycle after the fourth word is written.
- R8: While `blk_valid` is high and `core_ready` is low, `blk_valid` stays high and `blk_data` holds its value. Writes made in that time have no effect.
- R9: When `res_valid` is high and `res_ready` is high, the result is captured and `res_ready` falls. `rd_data` then shows bits [127:96], and each read moves it to the next lower lane. `res_ready` rises again after the fourth read. While `res_ready` is high, `rd_data` is zero.
- R10: A falling edge on either enable resets that direction's word counter, so the next access for that direction targets the most significant lane.
- R11: A write or read without an acknowledge (a CPU access) moves the same word counter as a DMA transfer.
- R12: A synchronous active-high `rst` clears both counters, both requests and both buffer states. After reset, `blk_valid` is 0 and `res_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_dma_en | input | 1 | Enables input DMA requests |
| out_dma_en | input | 1 | Enables output DMA requests |
| wr_valid | input | 1 | 32-bit write strobe (from DMA or CPU) |
| wr_data | input | 32 | Write data |
| in_ack | input | 1 | DMA acknowledge for the current input request |
| in_req | output | 1 | Input DMA request |
| rd_valid | input | 1 | 32-bit read strobe (from DMA or CPU) |
| rd_data | output | 32 | Current output word |
| out_ack | input | 1 | DMA acknowledge for the current output request |
| out_req | output | 1 | Output DMA request |
| blk_valid | output | 1 | Assembled block ready for the core |
| blk_data | output | 128 | Assembled input block |
| core_ready | input | 1 | Core accepts the assembled block |
| res_valid | input | 1 | Core presents a finished result |
| res_data | input | 128 | Finished result block |
| res_ready | output | 1 | Output buffer empty, result may be loaded |

## Verification
The assertions check on every cycle that a request never coexists with a full input buffer or an empty output buffer, and that a request does not fall without an acknowledge. They also check that each request drops after its acknowledge, that a block waiting for the core stays stable, and that a captured result presents its top word first. Some behaviour can only be shown by the bench's scenarios, which compare the design against a reference model on every clock:
- the exact lane each word lands in across a whole block;
- the restart at the top lane after an enable is cleared partway through;
- a block filled partly by CPU writes and partly by DMA;
- a result drained by a mix of reads.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  // Lowest bit of the lane that holds word number idx (idx 0 = first in time = most significant).
  function automatic int unsigned word_lsb(input int unsigned idx,
                                           input int unsigned words,
                                           input int unsigned width);
    return (words - 1 - idx) * width;
  endfunction

  // True when idx is the last word of a block.
  function automatic logic is_last(input int unsigned idx, input int unsigned words);
    return idx == words - 1;
  endfunction
endpackage

// File: rtl/dbb_req_ctl.sv
module dbb_req_ctl (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  input  logic need_n,
  output logic req
);
  logic req_q;

  // An acknowledge forces one low cycle; the request returns if words are still needed.
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= en & ~ack & need_n;
  end

  assign req = req_q & en;
endmodule

// File: rtl/dbb_in_asm.sv
module dbb_in_asm
  import dbb_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       wr_valid,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       core_ready,
  output logic                       blk_valid,
  output logic [WORD_W*WORDS-1:0]    blk_data,
  output logic                       full_n,
  output logic                       en_fall
);
  localparam int unsigned BLK_W = WORD_W * WORDS;
  localparam int unsigned CW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CW-1:0]    wcnt_q, wcnt_n;
  logic             full_q;
  logic [BLK_W-1:0] buf_q, buf_n;
  logic             en_q;

  assign en_fall = en_q & ~en;

  always_comb begin
    wcnt_n = wcnt_q;
    full_n = full_q;
    buf_n  = buf_q;
    if (full_q) begin
      if (core_ready) full_n = 1'b0;
    end else if (en_fall) begin
      wcnt_n = '0;
    end else if (wr_valid) begin
      buf_n[word_lsb(32'(wcnt_q), WORDS, WORD_W) +: WORD_W] = wr_data;
      if (is_last(32'(wcnt_q), WORDS)) begin
        full_n = 1'b1;
        wcnt_n = '0;
      end else begin
        wcnt_n = wcnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q <= '0;
      full_q <= 1'b0;
      buf_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      wcnt_q <= wcnt_n;
      full_q <= full_n;
      buf_q  <= buf_n;
      en_q   <= en;
    end
  end

  assign blk_valid = full_q;
  assign blk_data  = buf_q;
endmodule

// File: rtl/dbb_out_split.sv
module dbb_out_split
  import dbb_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       rd_valid,
  input  logic                       res_valid,
  input  logic [WORD_W*WORDS-1:0]    res_data,
  output logic                       res_ready,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       full_n,
  output logic                       en_fall
);
  localparam int unsigned BLK_W = WORD_W * WORDS;
  localparam int unsigned CW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CW-1:0]    rcnt_q, rcnt_n;
  logic             full_q;
  logic [BLK_W-1:0] buf_q, buf_n;
  logic             en_q;

  assign en_fall = en_q & ~en;

  always_comb begin
    rcnt_n = rcnt_q;
    full_n = full_q;
    buf_n  = buf_q;
    if (full_q) begin
      if (en_fall) begin
        rcnt_n = '0;
      end else if (rd_valid) begin
        if (is_last(32'(rcnt_q), WORDS)) begin
          full_n = 1'b0;
          rcnt_n = '0;
        end else begin
          rcnt_n = rcnt_q + CW'(1);
        end
      end
    end else if (res_valid) begin
      buf_n  = res_data;
      full_n = 1'b1;
      rcnt_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt_q <= '0;
      full_q <= 1'b0;
      buf_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      rcnt_q <= rcnt_n;
      full_q <= full_n;
      buf_q  <= buf_n;
      en_q   <= en;
    end
  end

  assign res_ready = ~full_q;
  assign rd_data   = full_q ? buf_q[word_lsb(32'(rcnt_q), WORDS, WORD_W) +: WORD_W] : '0;
endmodule

// File: rtl/dma_blkbuf.sv
module dma_blkbuf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_dma_en,
  input  logic                    out_dma_en,
  input  logic                    wr_valid,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    in_ack,
  output logic                    in_req,
  input  logic                    rd_valid,
  output logic [WORD_W-1:0]       rd_data,
  input  logic                    out_ack,
  output logic                    out_req,
  output logic                    blk_valid,
  output logic [WORD_W*WORDS-1:0] blk_data,
  input  logic                    core_ready,
  input  logic                    res_valid,
  input  logic [WORD_W*WORDS-1:0] res_data,
  output logic                    res_ready
);
  // Named internal events, visible to the bound checker.
  logic in_full_n, in_en_fall;
  logic out_full_n, out_en_fall;
  logic in_need_n, out_need_n;

  dbb_in_asm #(.WORD_W(WORD_W), .WORDS(WORDS)) u_in (
    .clk(clk), .rst(rst), .en(in_dma_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .core_ready(core_ready),
    .blk_valid(blk_valid), .blk_data(blk_data),
    .full_n(in_full_n), .en_fall(in_en_fall)
  );

  dbb_out_split #(.WORD_W(WORD_W), .WORDS(WORDS)) u_out (
    .clk(clk), .rst(rst), .en(out_dma_en),
    .rd_valid(rd_valid), .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .rd_data(rd_data),
    .full_n(out_full_n), .en_fall(out_en_fall)
  );

  assign in_need_n  = ~in_full_n;
  assign out_need_n = out_full_n;

  dbb_req_ctl u_in_req (
    .clk(clk), .rst(rst), .en(in_dma_en), .ack(in_ack),
    .need_n(in_need_n), .req(in_req)
  );

  dbb_req_ctl u_out_req (
    .clk(clk), .rst(rst), .en(out_dma_en), .ack(out_ack),
    .need_n(out_need_n), .req(out_req)
  );
endmodule

// File: rtl/dma_blkbuf_chk.sv
module dma_blkbuf_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_dma_en,
  input logic                    out_dma_en,
  input logic                    wr_valid,
  input logic                    in_ack,
  input logic                    in_req,
  input logic                    rd_valid,
  input logic [WORD_W-1:0]       rd_data,
  input logic                    out_ack,
  input logic                    out_req,
  input logic                    blk_valid,
  input logic [WORD_W*WORDS-1:0] blk_data,
  input logic                    core_ready,
  input logic                    res_valid,
  input logic [WORD_W-1:0]       res_top,
  input logic                    res_ready
);
  assert_fall_drops_req_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(in_dma_en) |=> !in_req);

  assert_out_fall_drops_req_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(out_dma_en) |=> !out_req);

  assert_no_in_req_when_full_R3: assert property (@(posedge clk) disable iff (rst)
    in_req |-> !blk_valid);

  assert_out_req_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
    out_req |-> !res_ready);

  assert_in_req_held_R5: assert property (@(posedge clk) disable iff (rst)
    in_req && !in_ack && !wr_valid |=> in_req || !in_dma_en || blk_valid);

  assert_out_req_held_R5: assert property (@(posedge clk) disable iff (rst)
    out_req && !out_ack && !rd_valid |=> out_req || !out_dma_en || res_ready);

  assert_in_gap_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    in_req && in_ack |=> !in_req);

  assert_out_gap_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    out_req && out_ack |=> !out_req);

  assert_blk_stable_R8: assert property (@(posedge clk) disable iff (rst)
    blk_valid && !core_ready |=> blk_valid && $stable(blk_data));

  assert_result_capture_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_ready |=> !res_ready && rd_data == $past(res_top));
endmodule

bind dma_blkbuf dma_blkbuf_chk #(.WORD_W(WORD_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst(rst), .in_dma_en(in_dma_en), .out_dma_en(out_dma_en),
  .wr_valid(wr_valid), .in_ack(in_ack), .in_req(in_req),
  .rd_valid(rd_valid), .rd_data(rd_data), .out_ack(out_ack), .out_req(out_req),
  .blk_valid(blk_valid), .blk_data(blk_data), .core_ready(core_ready),
  .res_valid(res_valid), .res_top(res_data[WORD_W*WORDS-1 -: WORD_W]),
  .res_ready(res_ready)
);

// File: tb/sim_dma_blkbuf.sv
`timescale 1ns/1ps
module sim_dma_blkbuf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_dma_en = 0, out_dma_en = 0, wr_valid = 0, in_ack = 0;
  logic rd_valid = 0, out_ack = 0, core_ready = 0, res_valid = 0;
  logic [31:0]  wr_data = '0;
  logic [127:0] res_data = '0;
  logic in_req, out_req, blk_valid, res_ready;
  logic [31:0]  rd_data;
  logic [127:0] blk_data;

  int checks = 0, errors = 0;
  bit run_cmp = 0;

  always #2.5 clk = ~clk;

  dma_blkbuf u0 (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_inq[$];
  bit          m_full, m_inreq_q, m_in_en_q;
  bit [127:0]  m_blk;
  bit          m_ofull, m_outreq_q, m_out_en_q;
  bit [127:0]  m_res;
  int          m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_inq.delete(); m_full = 0; m_inreq_q = 0; m_in_en_q = 0; m_blk = '0;
      m_ofull = 0; m_outreq_q = 0; m_out_en_q = 0; m_res = '0; m_rd = 0;
    end else begin
      // input direction
      if (m_full) begin
        if (core_ready) m_full = 0;
      end else if (m_in_en_q && !in_dma_en) begin
        m_inq.delete();                       // R10
      end else if (wr_valid) begin
        m_inq.push_back(wr_data);             // R11: any write counts
        if (m_inq.size() == 4) begin
          m_blk = {m_inq[0], m_inq[1], m_inq[2], m_inq[3]};
          m_inq.delete();
          m_full = 1;
        end
      end
      m_inreq_q = in_dma_en && !in_ack && !m_full;
      m_in_en_q = in_dma_en;
      // output direction
      if (m_ofull) begin
        if (m_out_en_q && !out_dma_en) m_rd = 0;
        else if (rd_valid) begin
          m_rd++;
          if (m_rd == 4) begin m_rd = 0; m_ofull = 0; end
        end
      end else if (res_valid) begin
        m_res = res_data; m_ofull = 1; m_rd = 0;
      end
      m_outreq_q = out_dma_en && !out_ack && m_ofull;
      m_out_en_q = out_dma_en;
    end
    #1;
    if (run_cmp) begin
      chk("R1 R3 R5 R6 in_req", 128'(in_req), 128'(m_inreq_q && in_dma_en));
      chk("R2 R4 R5 R6 out_req", 128'(out_req), 128'(m_outreq_q && out_dma_en));
      chk("R7 R8 blk_valid", 128'(blk_valid), 128'(m_full));
      if (m_full) chk("R7 R8 blk_data", blk_data, m_blk);
      chk("R9 res_ready", 128'(res_ready), 128'(!m_ofull));
      chk("R9 R10 rd_data", 128'(rd_data),
          m_ofull ? 128'(m_res[(3-m_rd)*32 +: 32]) : 128'(0));
    end
  end

  task automatic dma_write(input logic [31:0] w);
    do @(negedge clk); while (!in_req);
    wr_valid = 1; in_ack = 1; wr_data = w;
    @(negedge clk);
    wr_valid = 0; in_ack = 0;
  endtask

  task automatic cpu_write(input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1; wr_data = w;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic dma_read(output logic [31:0] w);
    do @(negedge clk); while (!out_req);
    w = rd_data;
    rd_valid = 1; out_ack = 1;
    @(negedge clk);
    rd_valid = 0; out_ack = 0;
  endtask

  task automatic cpu_read(output logic [31:0] w);
    @(negedge clk);
    w = rd_data;
    rd_valid = 1;
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic accept_block;
    @(negedge clk); core_ready = 1;
    @(negedge clk); core_ready = 0;
  endtask

  task automatic load_result(input logic [127:0] r);
    @(negedge clk); res_valid = 1; res_data = r;
    @(negedge clk); res_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 0;
    run_cmp = 1;
    @(negedge clk);
    // R12: state after reset
    chk("R12 in_req", 128'(in_req), 0);
    chk("R12 out_req", 128'(out_req), 0);
    chk("R12 blk_valid", 128'(blk_valid), 0);
    chk("R12 res_ready", 128'(res_ready), 1);

    // R1: disabled, no requests
    repeat (4) @(negedge clk);
    chk("R1 idle in_req", 128'(in_req), 0);

    // R7: full DMA block, MSW first
    in_dma_en = 1;
    dma_write(32'hA0A0_0001); dma_write(32'hB1B1_0002);
    dma_write(32'hC2C2_0003); dma_write(32'hD3D3_0004);
    chk("R7 block order", blk_data, 128'hA0A0_0001_B1B1_0002_C2C2_0003_D3D3_0004);
    chk("R3 no req while full", 128'(in_req), 0);
    // R8: write while waiting is ignored
    cpu_write(32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk("R8 held data", blk_data, 128'hA0A0_0001_B1B1_0002_C2C2_0003_D3D3_0004);
    chk("R8 held valid", 128'(blk_valid), 1);
    accept_block();

    // R10: clear enable mid-block, restart at top lane
    dma_write(32'h1111_1111); dma_write(32'h2222_2222);
    @(negedge clk); in_dma_en = 0;
    @(negedge clk); in_dma_en = 1;
    dma_write(32'h5555_0000); dma_write(32'h6666_0000);
    dma_write(32'h7777_0000); dma_write(32'h8888_0000);
    chk("R10 restart", blk_data, 128'h5555_0000_6666_0000_7777_0000_8888_0000);
    accept_block();

    // R11: CPU writes with DMA off, DMA finishes the block
    in_dma_en = 0;
    cpu_write(32'h0C0C_0001); cpu_write(32'h0C0C_0002);
    in_dma_en = 1;
    dma_write(32'h0D0D_0003); dma_write(32'h0D0D_0004);
    chk("R11 mixed", blk_data, 128'h0C0C_0001_0C0C_0002_0D0D_0003_0D0D_0004);
    accept_block();
    in_dma_en = 0;

    // R2 and R9: result held, output DMA disabled
    load_result(128'h9999_0001_8888_0002_7777_0003_6666_0004);
    repeat (3) @(negedge clk);
    chk("R2 no out_req", 128'(out_req), 0);
    chk("R9 res_ready low", 128'(res_ready), 0);
    cpu_read(w);
    chk("R9 R11 cpu read msw", 128'(w), 128'h9999_0001);
    out_dma_en = 1;
    dma_read(w); chk("R9 word1", 128'(w), 128'h8888_0002);
    // R10: drop output enable, reads restart at top
    @(negedge clk); out_dma_en = 0;
    @(negedge clk); out_dma_en = 1;
    dma_read(w); chk("R10 out restart", 128'(w), 128'h9999_0001);
    dma_read(w); chk("R9 word1b", 128'(w), 128'h8888_0002);
    dma_read(w); chk("R9 word2", 128'(w), 128'h7777_0003);
    dma_read(w); chk("R9 word3", 128'(w), 128'h6666_0004);
    @(negedge clk);
    chk("R9 drained", 128'(res_ready), 1);
    chk("R9 zero when empty", 128'(rd_data), 0);

    // Second result, pure DMA, enable stays on
    load_result(128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10);
    dma_read(w); chk("R9 r2 w0", 128'(w), 128'h0102_0304);
    dma_read(w); chk("R9 r2 w1", 128'(w), 128'h0506_0708);
    dma_read(w); chk("R9 r2 w2", 128'(w), 128'h090A_0B0C);
    dma_read(w); chk("R9 r2 w3", 128'(w), 128'h0D0E_0F10);
    out_dma_en = 0;

    // R12: reset mid-activity
    in_dma_en = 1;
    dma_write(32'h1234_5678);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; in_dma_en = 0;
    @(negedge clk);
    chk("R12 reset in_req", 128'(in_req), 0);
    chk("R12 reset res_ready", 128'(res_ready), 1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule